// File: doc/BRIEF.md
# Interrupt Status and Cause Register Unit

This unit sits beside a processor pipeline and decides whether a trap is taken. It holds two software-visible registers. The status register carries a global interrupt enable, an exception-level flag and one mask bit per device interrupt line. The cause register carries one pending bit per line, a 5-bit trap code and the number of the interrupt level that was last taken.

Device lines set their pending bits even while masked. A pending bit stays set until its line drops or until software clears it. An interrupt is taken only when the global enable is on, the exception-level flag is off, and some pending bit has its mask bit set. A taken trap raises a one-cycle pulse toward the pipeline, sets the exception-level flag so that no further interrupt is taken, and records the code. The pipeline can also report a synchronous exception with its own code, and that exception is taken unconditionally. Software returns from a handler by writing the status register with the exception-level flag cleared.

Top module: `irq_status_cause`

## Requirements
- R1: After reset, both registers read as zero and `trap_o` is low.
- R2: A rising edge on `irq_i[i]` sets pending bit i (cause bits [15:8]) at the next clock edge, whatever the mask, the enable and the exception-level flag.
- R3: A pending bit whose line is low at a clock edge reads 0 after that edge.
- R4: A write to the cause register (`reg_sel_i`=1) clears each pending bit whose bit in `reg_wdata_i[15:8]` is 1. It leaves the other pending bits, the code and the level unchanged.
- R5: With enable (status bit 0) at 1, exception level (status bit 1) at 0 and a pending bit whose mask (status bits [15:8]) is 1, `trap_o` pulses high for exactly one cycle, the clock edge after the pending bit is visible. That edge sets the exception level and writes code 0 to cause bits [6:2].
- R6: No interrupt is taken while the enable bit is 0, or while every pending bit is masked.
- R7: While the exception level is 1, pending bits keep latching but no interrupt is taken.
- R8: A status write (`reg_sel_i`=0) loads enable, exception level and mask from `reg_wdata_i`. Writing exception level 0 acts as a return, after which a still-pending unmasked interrupt is taken at the next edge.
- R9: When several unmasked pending bits exist, the highest-numbered one is recorded as the level in cause bits [18:16].
- R10: `exc_req_i` high at an edge takes a trap regardless of enable and exception level. It records `exc_code_i` as the code, sets the exception level, and wins over an interrupt taken at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | N_LINES | Device interrupt lines, level high |
| exc_req_i | input | 1 | Synchronous exception request from the pipeline |
| exc_code_i | input | CODE_W | Code of that exception |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | Register select: 0 status, 1 cause |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data of the selected register |
| trap_o | output | 1 | One-cycle pulse: take a trap |

## Verification
The bench builds the unit with its default of eight lines and a 5-bit code. With eight lines, the level field uses its full three bits, and line 6 can win the priority choice over line 4. All eight mask and pending positions can then be written and read. With a 5-bit code, an exception code such as 13 can be told apart from the reserved interrupt code 0. This shows when an exception and an interrupt meet at the same edge and the exception wins.

// File: rtl/irq_pkg.sv
package irq_pkg;

    // register select values on the software port
    localparam logic SEL_STATUS = 1'b0;
    localparam logic SEL_CAUSE  = 1'b1;

    // field positions shared by both registers
    localparam int unsigned POS_IE    = 0;
    localparam int unsigned POS_EXL   = 1;
    localparam int unsigned POS_CODE  = 2;
    localparam int unsigned POS_LINES = 8;
    localparam int unsigned POS_LVL   = 16;
    localparam int unsigned REG_W     = 32;

    // trap code written for an external interrupt
    localparam int unsigned CODE_EXT_IRQ = 0;

endpackage

// File: rtl/irq_pend.sv
module irq_pend #(
    parameter int unsigned N_LINES = 8
) (
    input  logic [N_LINES-1:0] line_i,
    input  logic [N_LINES-1:0] prev_i,
    input  logic [N_LINES-1:0] pend_i,
    input  logic [N_LINES-1:0] clr_i,
    output logic [N_LINES-1:0] pend_o
);
    for (genvar i = 0; i < N_LINES; i++) begin : g_bit
        logic rise;
        assign rise      = line_i[i] & ~prev_i[i];
        // a new edge beats a clear in the same cycle; a low line always drops it
        assign pend_o[i] = line_i[i] & (rise | (pend_i[i] & ~clr_i[i]));
    end
endmodule

// File: rtl/irq_prio.sv
module irq_prio #(
    parameter int unsigned N_LINES = 8,
    localparam int unsigned LVL_W = (N_LINES > 1) ? $clog2(N_LINES) : 1
) (
    input  logic [N_LINES-1:0] req_i,
    output logic [LVL_W-1:0]   lvl_o
);
    always_comb begin
        lvl_o = '0;
        for (int i = 0; i < N_LINES; i++) begin
            if (req_i[i]) lvl_o = LVL_W'(i);
        end
    end
endmodule

// File: rtl/irq_status_cause.sv
module irq_status_cause #(
    parameter int unsigned N_LINES = 8,
    parameter int unsigned CODE_W  = 5,
    localparam int unsigned LVL_W  = (N_LINES > 1) ? $clog2(N_LINES) : 1
) (
    input  logic                          clk_i,
    input  logic                          rst_ni,
    input  logic [N_LINES-1:0]            irq_i,
    input  logic                          exc_req_i,
    input  logic [CODE_W-1:0]             exc_code_i,
    input  logic                          reg_we_i,
    input  logic                          reg_sel_i,
    input  logic [irq_pkg::REG_W-1:0]     reg_wdata_i,
    output logic [irq_pkg::REG_W-1:0]     reg_rdata_o,
    output logic                          trap_o
);
    import irq_pkg::*;

    typedef struct packed {
        logic               ie;
        logic               exl;
        logic [N_LINES-1:0] mask;
        logic [N_LINES-1:0] pend;
        logic [N_LINES-1:0] prev;
        logic [CODE_W-1:0]  code;
        logic [LVL_W-1:0]   lvl;
        logic               trap;
    } state_t;

    state_t state_d, state_q;

    logic [N_LINES-1:0] clr_w;
    logic [N_LINES-1:0] pend_nx;
    logic [N_LINES-1:0] ready_w;
    logic [LVL_W-1:0]   lvl_w;
    logic               wr_status, wr_cause;
    logic               unused_wdata;

    assign wr_status    = reg_we_i && (reg_sel_i == SEL_STATUS);
    assign wr_cause     = reg_we_i && (reg_sel_i == SEL_CAUSE);
    assign clr_w        = wr_cause ? reg_wdata_i[POS_LINES +: N_LINES] : '0;
    assign ready_w      = state_q.pend & state_q.mask;
    assign unused_wdata = ^{reg_wdata_i[REG_W-1:POS_LINES+N_LINES], reg_wdata_i[POS_LINES-1:POS_EXL+1]};

    irq_pend #(.N_LINES(N_LINES)) i_pend (
        .line_i (irq_i),
        .prev_i (state_q.prev),
        .pend_i (state_q.pend),
        .clr_i  (clr_w),
        .pend_o (pend_nx)
    );

    irq_prio #(.N_LINES(N_LINES)) i_prio (
        .req_i (ready_w),
        .lvl_o (lvl_w)
    );

    always_comb begin
        state_d      = state_q;
        state_d.trap = 1'b0;
        state_d.prev = irq_i;
        state_d.pend = pend_nx;
        if (wr_status) begin
            state_d.ie   = reg_wdata_i[POS_IE];
            state_d.exl  = reg_wdata_i[POS_EXL];
            state_d.mask = reg_wdata_i[POS_LINES +: N_LINES];
        end
        if (exc_req_i) begin
            state_d.trap = 1'b1;
            state_d.exl  = 1'b1;
            state_d.code = exc_code_i;
        end else if (state_q.ie && !state_q.exl && (|ready_w)) begin
            state_d.trap = 1'b1;
            state_d.exl  = 1'b1;
            state_d.code = CODE_W'(CODE_EXT_IRQ);
            state_d.lvl  = lvl_w;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= '0;
        else         state_q <= state_d;
    end

    always_comb begin
        reg_rdata_o = '0;
        if (reg_sel_i == SEL_STATUS) begin
            reg_rdata_o[POS_IE]                 = state_q.ie;
            reg_rdata_o[POS_EXL]                = state_q.exl;
            reg_rdata_o[POS_LINES +: N_LINES]   = state_q.mask;
        end else begin
            reg_rdata_o[POS_CODE +: CODE_W]     = state_q.code;
            reg_rdata_o[POS_LINES +: N_LINES]   = state_q.pend;
            reg_rdata_o[POS_LVL +: LVL_W]       = state_q.lvl;
        end
    end

    assign trap_o = state_q.trap;

endmodule

// File: rtl/irq_status_cause_chk.sv
module irq_status_cause_chk #(
    parameter int unsigned N_LINES = 8,
    parameter int unsigned CODE_W  = 5
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic [N_LINES-1:0] irq_i,
    input logic               exc_req_i,
    input logic [CODE_W-1:0]  exc_code_i,
    input logic               trap_o,
    input logic               ie_q,
    input logic               exl_q,
    input logic [N_LINES-1:0] pend_q,
    input logic [N_LINES-1:0] prev_q,
    input logic [CODE_W-1:0]  code_q
);
    // R2
    rise_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|(irq_i & ~prev_q)) |=> ((pend_q & $past(irq_i & ~prev_q)) == $past(irq_i & ~prev_q)));

    // R3
    low_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rst_ni |=> ((pend_q & ~$past(irq_i)) == '0));

    // R5
    trap_sets_exl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        trap_o |-> exl_q);

    // R5
    irq_single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (trap_o && !exc_req_i) |=> !trap_o);

    // R6
    ie_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!ie_q && !exc_req_i) |=> !trap_o);

    // R7
    exl_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (exl_q && !exc_req_i) |=> !trap_o);

    // R10
    exc_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        exc_req_i |=> (trap_o && (code_q == $past(exc_code_i))));
endmodule

bind irq_status_cause irq_status_cause_chk #(.N_LINES(N_LINES), .CODE_W(CODE_W)) i_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .irq_i      (irq_i),
    .exc_req_i  (exc_req_i),
    .exc_code_i (exc_code_i),
    .trap_o     (trap_o),
    .ie_q       (state_q.ie),
    .exl_q      (state_q.exl),
    .pend_q     (state_q.pend),
    .prev_q     (state_q.prev),
    .code_q     (state_q.code)
);

// File: tb/test_irq_status_cause.sv
module test_irq_status_cause;
    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic [7:0]  irq_i = '0;
    logic        exc_req_i = 1'b0;
    logic [4:0]  exc_code_i = '0;
    logic        reg_we_i = 1'b0;
    logic        reg_sel_i = 1'b0;
    logic [31:0] reg_wdata_i = '0;
    logic [31:0] reg_rdata_o;
    logic        trap_o;

    int total = 0;
    int bad = 0;

    always #4 clk_i = ~clk_i;

    irq_status_cause i_irq_status_cause (
        .clk_i, .rst_ni, .irq_i, .exc_req_i, .exc_code_i,
        .reg_we_i, .reg_sel_i, .reg_wdata_i, .reg_rdata_o, .trap_o
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk_i);
    endtask

    function automatic logic [31:0] status_word(logic ie, logic exl, logic [7:0] mask);
        return {16'b0, mask, 6'b0, exl, ie};
    endfunction

    function automatic logic [31:0] cause_word(logic [2:0] lvl, logic [7:0] pend, logic [4:0] code);
        return {13'b0, lvl, pend, 1'b0, code, 2'b0};
    endfunction

    task automatic rd(logic sel, output logic [31:0] v);
        reg_sel_i = sel;
        #1;
        v = reg_rdata_o;
    endtask

    task automatic wr(logic sel, logic [31:0] data);
        reg_we_i = 1'b1; reg_sel_i = sel; reg_wdata_i = data;
        tick();
        reg_we_i = 1'b0; reg_wdata_i = '0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(1'b0, v); check("R1 status", v, 32'h0);
        rd(1'b1, v); check("R1 cause", v, 32'h0);
        check("R1 trap", {31'b0, trap_o}, 32'h0);
    endtask

    task automatic t_masked_latch();
        logic [31:0] v;
        wr(1'b0, status_word(1'b1, 1'b0, 8'h00));
        irq_i[3] = 1'b1;
        tick();
        rd(1'b1, v); check("R2 masked pending", v, cause_word(3'd0, 8'h08, 5'd0));
        tick(); check("R6 masked no trap", {31'b0, trap_o}, 32'h0);
        tick(); check("R6 masked no trap later", {31'b0, trap_o}, 32'h0);
        irq_i[3] = 1'b0;
        tick();
        rd(1'b1, v); check("R3 low drops pending", v, 32'h0);
    endtask

    task automatic t_take_and_block();
        logic [31:0] v;
        wr(1'b0, status_word(1'b1, 1'b0, 8'h10));
        irq_i[4] = 1'b1;
        tick();
        check("R5 no trap yet", {31'b0, trap_o}, 32'h0);
        tick();
        check("R5 trap pulse", {31'b0, trap_o}, 32'h1);
        rd(1'b1, v); check("R5 R9 cause code 0 level 4", v, cause_word(3'd4, 8'h10, 5'd0));
        rd(1'b0, v); check("R5 exl set", v, status_word(1'b1, 1'b1, 8'h10));
        tick();
        check("R5 pulse one cycle", {31'b0, trap_o}, 32'h0);
        // R7: new line while exl is set
        wr(1'b0, status_word(1'b1, 1'b1, 8'hFF));
        irq_i[6] = 1'b1;
        tick();
        rd(1'b1, v); check("R7 pending latches under exl", v, cause_word(3'd4, 8'h50, 5'd0));
        tick(); check("R7 no trap under exl", {31'b0, trap_o}, 32'h0);
        // R8: return clears exl, pending 6 and 4 unmasked
        wr(1'b0, status_word(1'b1, 1'b0, 8'hFF));
        rd(1'b0, v); check("R8 status loaded", v, status_word(1'b1, 1'b0, 8'hFF));
        tick();
        check("R8 trap after return", {31'b0, trap_o}, 32'h1);
        rd(1'b1, v); check("R9 highest level 6", v, cause_word(3'd6, 8'h50, 5'd0));
    endtask

    task automatic t_w1c();
        logic [31:0] v;
        wr(1'b1, 32'h0000_4000);
        rd(1'b1, v); check("R4 clear bit 6 only", v, cause_word(3'd6, 8'h10, 5'd0));
        tick();
        rd(1'b1, v); check("R4 stays clear with line held", v, cause_word(3'd6, 8'h10, 5'd0));
    endtask

    task automatic t_ie_off();
        wr(1'b0, status_word(1'b0, 1'b0, 8'hFF));
        tick(); check("R6 ie off no trap", {31'b0, trap_o}, 32'h0);
        tick(); check("R6 ie off no trap later", {31'b0, trap_o}, 32'h0);
    endtask

    task automatic t_exception();
        logic [31:0] v;
        exc_req_i = 1'b1; exc_code_i = 5'd13;
        tick();
        exc_req_i = 1'b0; exc_code_i = '0;
        check("R10 exception trap with ie off", {31'b0, trap_o}, 32'h1);
        rd(1'b1, v); check("R10 code 13", {27'b0, v[6:2]}, 32'd13);
        rd(1'b0, v); check("R10 exl set", {31'b0, v[1]}, 32'h1);
        // return with ie on; next edge has interrupt and exception together
        wr(1'b0, status_word(1'b1, 1'b0, 8'hFF));
        exc_req_i = 1'b1; exc_code_i = 5'd7;
        tick();
        exc_req_i = 1'b0; exc_code_i = '0;
        check("R10 trap at collision", {31'b0, trap_o}, 32'h1);
        rd(1'b1, v); check("R10 exception code wins", {27'b0, v[6:2]}, 32'd7);
        irq_i = '0;
        tick();
        rd(1'b1, v); check("R3 all lines low", {24'b0, v[15:8]}, 32'h0);
    endtask

    initial begin
        #200000;
        bad++; total++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        tick(); tick();
        t_reset();
        rst_ni = 1'b1;
        tick();
        t_reset();
        t_masked_latch();
        t_take_and_block();
        t_w1c();
        t_ie_off();
        t_exception();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule